// File: doc/BRIEF.md
# Half-Band Decimate-by-Two Filter

This block halves the sample rate of one real, signed sample stream with a half-band low-pass FIR. A receive chain puts one instance on the in-phase path and one on the quadrature path, after the mixer. Samples arrive with a valid strobe, one per valid cycle. Every second valid sample completes a pair, and the block then emits one filtered, rounded and saturated 16-bit sample.

The coefficient set is fixed at elaboration through a parameter array. Its length must be 4k+3. The block relies on the half-band shape: only the even-indexed taps and the centre tap are non-zero, and the even-indexed taps mirror each other about the centre. The filter is split into two polyphase branches. The second sample of each pair and the stored samples of the same parity feed pre-adders, one for each mirrored tap pair. The stored first-of-pair samples feed the lone centre tap. All arithmetic runs only when an output is due. The coefficient entries at the odd positions other than the centre are never read.

Top module: `hb_decim2`

## Requirements
- R1: Number the accepted samples from 0 after reset. When sample 2m+1 is accepted on a clock edge, out_valid is high for exactly the following cycle. No other cycle has out_valid high, so even-numbered samples never produce an output.
- R2: The output for pair m is y = sum over k of h[k]·x[2m+1−k], scaled down by 2^SHIFT. In this sum h[k] is treated as zero at every odd k except the centre k=(NTAPS−1)/2, and samples with negative index are zero.
- R3: Scaling adds 2^(SHIFT−1) to the full-precision sum and then shifts it arithmetically right by SHIFT, so halves round toward +infinity.
- R4: A scaled value above 32767 gives 32767 and one below −32768 gives −32768, for OUT_W=16. The full-precision sum never wraps.
- R5: A cycle with in_valid low changes no state: the sample count, the stored history and the outputs stay as they were.
- R6: Reset (rst_n low, asynchronous) clears the stored history and the pair count, and drives out_valid and out_data to 0.
- R7: out_data keeps its last value through every cycle in which out_valid is low.
- R8: The COEF entries at odd positions other than the centre have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W (14) | Signed input sample |
| out_valid | output | 1 | Output sample strobe, at most one cycle in two |
| out_data | output | OUT_W (16) | Signed filtered, decimated sample |

## Verification
A corrupted pair counter shows up on the very next output. The strobe then appears after an even-numbered sample, or fails to appear after an odd one. A wrong entry in either delay line gives no sign until it reaches a tap. It then corrupts every output for up to NTAPS/2 pairs, and an impulse shows it as a wrong or missing coefficient at a known output index. Sweeping every input code through two configurations, one of them driven into saturation, shows rounding and clipping faults within a single output.

// File: rtl/hb_decim2.sv
module hb_decim2 #(
  parameter int NTAPS  = 11,
  parameter int IN_W   = 14,
  parameter int OUT_W  = 16,
  parameter int COEF_W = 16,
  parameter int SHIFT  = 15,
  parameter logic signed [COEF_W-1:0] COEF [NTAPS] = '{
    16'sd300, 16'sd0, -16'sd1800, 16'sd0, 16'sd9700, 16'sd16384,
    16'sd9700, 16'sd0, -16'sd1800, 16'sd0, 16'sd300}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int K     = (NTAPS - 3) / 4;
  localparam int NODD  = 2 * K + 2;
  localparam int NPAIR = K + 1;
  localparam int CTR   = (NTAPS - 1) / 2;
  localparam int ACC_W = IN_W + 1 + COEF_W + $clog2(NPAIR + 1) + 1;
  localparam logic signed [ACC_W-1:0] OMAX = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OMIN = -OMAX - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (SHIFT - 1);

  logic                   phase;
  logic signed [IN_W-1:0] odd_q  [NODD-1];
  logic signed [IN_W-1:0] even_q [K+1];
  logic signed [IN_W-1:0] odd_w  [NODD];
  logic signed [ACC_W-1:0] prod  [NPAIR];
  logic signed [ACC_W-1:0] ctr_prod, acc, rnd, scaled;
  logic signed [OUT_W-1:0] sat;

  assign odd_w[0] = in_data;
  for (genvar j = 1; j < NODD; j++) begin : g_tap
    assign odd_w[j] = odd_q[j-1];
  end

  for (genvar j = 0; j < NPAIR; j++) begin : g_pair
    logic signed [IN_W:0] pre;
    assign pre     = (IN_W+1)'(odd_w[j]) + (IN_W+1)'(odd_w[NODD-1-j]);
    assign prod[j] = ACC_W'(pre) * ACC_W'(COEF[2*j]);
  end

  assign ctr_prod = ACC_W'(even_q[K]) * ACC_W'(COEF[CTR]);

  always_comb begin
    acc = ctr_prod;
    for (int j = 0; j < NPAIR; j++) acc = acc + prod[j];
  end

  assign rnd    = acc + HALF;
  assign scaled = rnd >>> SHIFT;
  assign sat    = (scaled > OMAX) ? OUT_W'(OMAX) :
                  (scaled < OMIN) ? OUT_W'(OMIN) : OUT_W'(scaled);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int i = 0; i < NODD-1; i++) odd_q[i] <= '0;
      for (int i = 0; i <= K; i++) even_q[i] <= '0;
    end else begin
      out_valid <= in_valid && phase;
      if (in_valid) begin
        phase <= ~phase;
        if (!phase) begin
          even_q[0] <= in_data;
          for (int i = 1; i <= K; i++) even_q[i] <= even_q[i-1];
        end else begin
          odd_q[0] <= in_data;
          for (int i = 1; i < NODD-1; i++) odd_q[i] <= odd_q[i-1];
          out_data <= sat;
        end
      end
    end
  end
endmodule

module hb_decim2_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  logic par_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) par_q <= 1'b0;
    else if (in_valid) par_q <= ~par_q;

  a_r1_pair_done: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && par_q) |=> out_valid);
  a_r1_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !par_q) |=> !out_valid);
  a_r1_no_back2back: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

bind hb_decim2 hb_decim2_chk #(.OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data));

// File: tb/hb_decim2_tb_top.sv
module hb_decim2_tb_top;
  localparam int NA = 11, SA = 15, NB = 7, SB = 12;
  // odd non-centre entries hold junk on purpose (R8)
  localparam logic signed [15:0] CA [NA] = '{16'sd300, 16'sd77, -16'sd1800,
    -16'sd91, 16'sd9700, 16'sd16384, 16'sd9700, 16'sd55, -16'sd1800, 16'sd13, 16'sd300};
  localparam logic signed [15:0] CB [NB] = '{-16'sd2000, 16'sd7, 16'sd10000,
    16'sd16000, 16'sd10000, 16'sd5, -16'sd2000};

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic signed [13:0] in_data = '0;
  logic va, vb;
  logic signed [15:0] da, db;
  always #2 clk = ~clk;

  hb_decim2 #(.NTAPS(NA), .SHIFT(SA), .COEF(CA)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(va), .out_data(da));
  hb_decim2 #(.NTAPS(NB), .SHIFT(SB), .COEF(CB)) dut_s (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(vb), .out_data(db));

  int checks = 0, errors = 0;
  int xs[$];
  bit pend = 0;
  int ea, eb, la, lb;
  string tag = "R2";

  function automatic int model(bit b);
    longint acc = 0;
    int n = b ? NB : NA;
    int s = b ? SB : SA;
    int c = (n - 1) / 2;
    int last = xs.size() - 1;
    for (int k = 0; k < n; k++) begin
      if (k % 2 == 1 && k != c) continue;
      if (last - k < 0) continue;
      acc += longint'(b ? CB[k] : CA[k]) * longint'(xs[last - k]);
    end
    acc = (acc + (longint'(1) <<< (s - 1))) >>> s;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s): actual %0d expected %0d at %0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic verify();
    check("R1 strobe A", int'(va), int'(pend));
    check("R1 strobe B", int'(vb), int'(pend));
    if (pend) begin
      check("R2 R3 R8 value A", int'(da), ea);
      check("R2 R4 R8 value B", int'(db), eb);
      la = ea; lb = eb;
    end else begin
      check("R7 hold A", int'(da), la);
      check("R7 hold B", int'(db), lb);
    end
  endtask

  task automatic step(bit v, int d);
    @(negedge clk);
    verify();
    in_valid = v;
    in_data = d[13:0];
    pend = 0;
    if (v) begin
      xs.push_back(d);
      if (xs.size() % 2 == 0) begin
        pend = 1; ea = model(0); eb = model(1);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    verify();
    rst_n = 0; in_valid = 0; pend = 0;
    @(negedge clk);
    check("R6 reset valid A", int'(va), 0);
    check("R6 reset valid B", int'(vb), 0);
    check("R6 reset data A", int'(da), 0);
    check("R6 reset data B", int'(db), 0);
    rst_n = 1;
    xs.delete(); la = 0; lb = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lf = 32'h1ACE5;
    @(negedge clk);
    check("R6 initial valid", int'(va), 0);
    check("R6 initial data", int'(da), 0);
    rst_n = 1;

    tag = "R2 R8 impulse";
    step(1, 8191);
    for (int i = 0; i < 30; i++) step(1, 0);
    tag = "R2 odd impulse";
    step(1, 0); step(1, -8192);
    for (int i = 0; i < 30; i++) step(1, 0);

    tag = "R5 gaps";
    for (int i = 0; i < 40; i++) begin
      step(1, (i * 977) % 8192 - 4096);
      for (int g = 0; g < i % 3; g++) step(0, 1234);
    end

    tag = "R4 dc max";
    for (int i = 0; i < 20; i++) step(1, 8191);
    tag = "R4 dc min";
    for (int i = 0; i < 20; i++) step(1, -8192);
    tag = "R4 alternating";
    for (int i = 0; i < 24; i++) step(1, (i % 2) ? -8192 : 8191);
    for (int i = 0; i < 24; i++) step(1, ((i / 2) % 2) ? -8192 : 8191);

    tag = "R6 mid-stream reset";
    step(1, 5000); step(1, -3000); step(1, 7000);
    do_reset();
    step(1, 8191);
    for (int i = 0; i < 16; i++) step(1, 0);

    tag = "R3 code sweep";
    for (int i = 0; i < 16384; i++) step(1, ((i * 5) % 16384) - 8192);

    tag = "R5 random";
    for (int i = 0; i < 3000; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >>> 17); lf = lf ^ (lf << 5);
      step(lf[3:0] != 4'h0, int'($signed(lf[29:16])));
    end
    step(0, 0); step(0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule